// File: doc/BRIEF.md
# Serial Command Read Engine

This block is the serial front end of a word-organised memory slave on a three-wire select/clock/data bus. While chip select is high, it watches the serial clock for rising edges and samples data-in on each one. It waits for a start bit, then collects a 2-bit opcode and an 8-bit address. For a read, it drives a zero dummy bit and then shifts a stored 16-bit word out on data-out, most significant bit first. A mode pin lets a read run on through successive addresses for as long as the select stays high. A protect-enable pin turns the same read into a fetch of the 8-bit protect-boundary register.

The serial inputs are treated as already synchronous to the system clock `clk`. A rising serial-clock edge is acted on in the first `clk` cycle after it is seen. Data-out has an explicit enable, `do_oe`, that stands for the tri-state control. The 128-word store is a bank of registers. Reset loads it with a fixed pattern that is computed from the address.

The control is a six-state machine:
- `S_IDLE` waits for a start bit and goes to `S_OPC` when one arrives.
- `S_OPC` goes to `S_ADR` after two opcode bits.
- `S_ADR` goes to `S_DUMMY` on a read opcode, or to `S_DONE` on any other opcode, once the eighth address bit is in.
- `S_DUMMY` goes to `S_DATA` on the next edge.
- `S_DATA` stays in `S_DATA` when it reloads the next word for a sequential read. Otherwise it goes to `S_DONE` after the last bit.
- Select going low returns every state to `S_IDLE`.

Top module: `mw_read_engine`

## Requirements
- R1: While chip select is low, and after reset, `do_oe` is 0. It falls in the clock cycle after select is seen low.
- R2: Zero bits on `di` before the start bit are ignored. The first serial-clock rise that samples `di`=1 while selected is taken as the start bit.
- R3: Only opcode binary 10 (first bit 1) is a read. After any other opcode and its 8 address bits, `do_oe` stays 0 until select goes low.
- R4: Address bit 7 is ignored, and bits 6..0 pick one of 128 words. The word at address a holds {a[6:0], 1, a[6:0] xor 7'h2A, 0}.
- R5: The rise that samples the last address bit of a read sets `do_oe`=1 and `do_o`=0, which is the dummy bit.
- R6: Each later rise presents the next data bit, D15 first and D0 last. `do_o` changes only in the cycle after a serial-clock rise.
- R7: With `seq_n` high, the rise after D0 releases the output (`do_oe`=0) until select goes low.
- R8: With `seq_n` low, the rise after D0 presents D15 of the word at the next address, with no dummy bit in between. The address wraps from 127 to 0.
- R9: If `prot_en` is high on the last address rise of a read, the dummy bit is followed by the 8-bit protect value (`PROT_VAL`), MSB first. The rise after its last bit releases the output, whatever the level of `seq_n`.
- R10: Select going low at any point abandons the command. The next command after select returns high is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| seq_n | input | 1 | Low selects the continuous multi-word read |
| prot_en | input | 1 | High turns a read into a protect-register read |
| do_o | output | 1 | Serial data out |
| do_oe | output | 1 | Output enable for data-out (0 means high impedance) |

## Verification
The bench reads a low address with leading zeros before the start bit, and a second address that has bit 7 set. This separates a correct 7-bit word select from one that uses all 8 address bits. It also runs a sequential read that starts at address 126 and crosses the wrap, which shows whether the next word follows D0 directly and whether 127 rolls to 0. A protect read with the sequential pin low must stop after 8 bits. A non-read opcode must keep the output silent. A command cut off by select mid-address, and another cut off mid-data, show that the machine restarts cleanly.

// File: rtl/mw_pkg.sv
package mw_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_OPC,
        S_ADR,
        S_DUMMY,
        S_DATA,
        S_DONE
    } mw_state_e;

    localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mw_sk_edge.sv
module mw_sk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sk,
    output logic sk_rise
);
    logic sk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sk_q <= 1'b0;
        else        sk_q <= sk;
    end

    assign sk_rise = sk & ~sk_q;
endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
    parameter int ADDR_W = 7,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] KEY = ADDR_W'(42);

    logic [WORD_W-1:0] mem [DEPTH];

    // Reset fills each entry with a pattern derived from its index.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= WORD_W'({ADDR_W'(i), 1'b1, ADDR_W'(i) ^ KEY, 1'b0});
            end
        end
    end

    assign rd_word = mem[rd_addr];
endmodule

// File: rtl/mw_cmd_fsm.sv
module mw_cmd_fsm
    import mw_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int WORD_W = 16,
    parameter int PROT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              di,
    input  logic              sk_rise,
    input  logic              seq_n,
    input  logic              prot_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_word,
    input  logic [PROT_W-1:0] prot_word,
    output logic              do_o,
    output logic              do_oe
);
    localparam int CMD_AW = ADDR_W + 1;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    mw_state_e         state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [1:0]        op;
    logic [CMD_AW-1:0] adr_sh;
    logic [ADDR_W-1:0] waddr;
    logic [WORD_W-1:0] sh;
    logic              is_prot;
    logic              last_adr;
    logic              last_bit;

    assign last_adr = (cnt == CNT_W'(CMD_AW - 1));
    assign last_bit = (cnt == '0);

    // In S_ADR the fetch address includes the bit being sampled now; elsewhere
    // it looks ahead to the next word for the continuous read.
    assign rd_addr = (state == S_ADR) ? {adr_sh[ADDR_W-2:0], di}
                                      : ADDR_W'(waddr + 1'b1);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (sk_rise && di) nxt = S_OPC;
            S_OPC:   if (sk_rise && cnt == CNT_W'(1)) nxt = S_ADR;
            S_ADR:   if (sk_rise && last_adr) nxt = (op == OP_READ) ? S_DUMMY : S_DONE;
            S_DUMMY: if (sk_rise) nxt = S_DATA;
            S_DATA:  if (sk_rise && last_bit) nxt = (!seq_n && !is_prot) ? S_DATA : S_DONE;
            S_DONE:  nxt = S_DONE;
        endcase
        if (!cs) nxt = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            op      <= '0;
            adr_sh  <= '0;
            waddr   <= '0;
            sh      <= '0;
            is_prot <= 1'b0;
            do_o    <= 1'b0;
            do_oe   <= 1'b0;
        end else if (!cs) begin
            cnt   <= '0;
            do_oe <= 1'b0;
        end else if (sk_rise) begin
            unique case (state)
                S_IDLE: cnt <= '0;
                S_OPC: begin
                    op  <= {op[0], di};
                    cnt <= (cnt == CNT_W'(1)) ? '0 : cnt + 1'b1;
                end
                S_ADR: begin
                    adr_sh <= {adr_sh[CMD_AW-2:0], di};
                    cnt    <= cnt + 1'b1;
                    if (last_adr && op == OP_READ) begin
                        is_prot <= prot_en;
                        waddr   <= rd_addr;
                        sh      <= prot_en ? {prot_word, {(WORD_W-PROT_W){1'b0}}} : rd_word;
                        do_oe   <= 1'b1;
                        do_o    <= 1'b0;
                    end
                end
                S_DUMMY: begin
                    do_o <= sh[WORD_W-1];
                    sh   <= sh << 1;
                    cnt  <= is_prot ? CNT_W'(PROT_W - 1) : CNT_W'(WORD_W - 1);
                end
                S_DATA: begin
                    if (!last_bit) begin
                        do_o <= sh[WORD_W-1];
                        sh   <= sh << 1;
                        cnt  <= cnt - 1'b1;
                    end else if (!seq_n && !is_prot) begin
                        do_o  <= rd_word[WORD_W-1];
                        sh    <= rd_word << 1;
                        waddr <= rd_addr;
                        cnt   <= CNT_W'(WORD_W - 1);
                    end else begin
                        do_oe <= 1'b0;
                    end
                end
                S_DONE: ;
            endcase
        end
    end

    a_r1_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> !do_oe);
    a_r2_idle_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !do_oe);
    a_r3_done_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE) |-> !do_oe);
    a_r5_dummy_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DUMMY) |-> (do_oe && !do_o));
    a_r6_change_on_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        !sk_rise |=> $stable(do_o));
    a_r9_prot_length: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && is_prot) |-> (cnt < CNT_W'(PROT_W)));
endmodule

// File: rtl/mw_read_engine.sv
module mw_read_engine #(
    parameter int          ADDR_W   = 7,
    parameter int          WORD_W   = 16,
    parameter int          PROT_W   = 8,
    parameter logic [7:0]  PROT_VAL = 8'h5B
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic seq_n,
    input  logic prot_en,
    output logic do_o,
    output logic do_oe
);
    logic              sk_rise;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_word;
    logic [PROT_W-1:0] prot_word;

    assign prot_word = PROT_W'(PROT_VAL);

    mw_sk_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sk      (sk),
        .sk_rise (sk_rise)
    );

    mw_word_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    mw_cmd_fsm #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PROT_W(PROT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs        (cs),
        .di        (di),
        .sk_rise   (sk_rise),
        .seq_n     (seq_n),
        .prot_en   (prot_en),
        .rd_addr   (rd_addr),
        .rd_word   (rd_word),
        .prot_word (prot_word),
        .do_o      (do_o),
        .do_oe     (do_oe)
    );
endmodule

// File: tb/mw_read_engine_tb.sv
module mw_read_engine_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0, seq_n = 1'b1, prot_en = 1'b0;
    logic do_o, do_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [1:0] exp_q [$];
    string      req_q [$];
    event       sample_ev;

    localparam logic [7:0] PROT = 8'h5B;

    always #2.5 clk = ~clk;

    mw_read_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
        .seq_n(seq_n), .prot_en(prot_en), .do_o(do_o), .do_oe(do_oe)
    );

    function automatic logic [15:0] word_of(input logic [6:0] a);
        return {a, 1'b1, a ^ 7'h2A, 1'b0};
    endfunction

    task automatic check(input logic eoe, input logic edo, input string r);
        checks++;
        if (do_oe !== eoe || (eoe && do_o !== edo)) begin
            errors++;
            $display("FAIL %s: oe=%b do=%b expected oe=%b do=%b", r, do_oe, do_o, eoe, edo);
        end
    endtask

    // Monitor: compares each sampled output with the next expected item.
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(e[1], e[0], r);
            end
        end
    end

    // One serial clock period; the expectation refers to the state after its rise.
    task automatic pulse(input logic d, input logic eoe, input logic edo, input string r);
        @(negedge clk);
        di = d;
        repeat (2) @(negedge clk);
        sk = 1'b1;
        repeat (4) @(negedge clk);
        sk = 1'b0;
        repeat (3) @(negedge clk);
        exp_q.push_back({eoe, edo});
        req_q.push_back(r);
        -> sample_ev;
    endtask

    task automatic set_cs(input logic v);
        @(negedge clk);
        cs = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_cmd(input int zeros, input logic [1:0] op, input logic [7:0] a,
                            input bit is_read);
        for (int i = 0; i < zeros; i++) pulse(1'b0, 1'b0, 1'b0, "R2");
        pulse(1'b1, 1'b0, 1'b0, "R2");
        pulse(op[1], 1'b0, 1'b0, "R3");
        pulse(op[0], 1'b0, 1'b0, "R3");
        for (int i = 7; i > 0; i--) pulse(a[i], 1'b0, 1'b0, "R4");
        pulse(a[0], is_read, 1'b0, is_read ? "R5" : "R3");
    endtask

    task automatic read_word(input logic [15:0] w, input int n, input string r);
        for (int i = 15; i > 15 - n; i--) pulse(1'b0, 1'b1, w[i], r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1'b0, 1'b0, "R1");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(1'b0, 1'b0, "R1");

        // Single read, leading zeros before the start bit.
        set_cs(1'b1);
        send_cmd(3, 2'b10, 8'h05, 1'b1);
        read_word(word_of(7'h05), 16, "R6");
        pulse(1'b0, 1'b0, 1'b0, "R7");
        pulse(1'b0, 1'b0, 1'b0, "R7");
        set_cs(1'b0);
        check(1'b0, 1'b0, "R1");

        // Address bit 7 set is ignored.
        set_cs(1'b1);
        send_cmd(0, 2'b10, 8'hB3, 1'b1);
        read_word(word_of(7'h33), 16, "R4");
        pulse(1'b0, 1'b0, 1'b0, "R7");
        set_cs(1'b0);

        // Sequential read across the wrap.
        seq_n = 1'b0;
        set_cs(1'b1);
        send_cmd(1, 2'b10, 8'h7E, 1'b1);
        read_word(word_of(7'h7E), 16, "R8");
        read_word(word_of(7'h7F), 16, "R8");
        read_word(word_of(7'h00), 16, "R8");
        read_word(word_of(7'h01), 5, "R8");
        set_cs(1'b0);
        check(1'b0, 1'b0, "R10");

        // Protect read stops after 8 bits even in sequential mode.
        prot_en = 1'b1;
        set_cs(1'b1);
        send_cmd(0, 2'b10, 8'h22, 1'b1);
        read_word({PROT, 8'h00}, 8, "R9");
        pulse(1'b0, 1'b0, 1'b0, "R9");
        pulse(1'b0, 1'b0, 1'b0, "R9");
        set_cs(1'b0);
        prot_en = 1'b0;
        seq_n = 1'b1;

        // Non-read opcode keeps output silent.
        set_cs(1'b1);
        send_cmd(0, 2'b11, 8'h05, 1'b0);
        for (int i = 0; i < 4; i++) pulse(1'b1, 1'b0, 1'b0, "R3");
        set_cs(1'b0);

        // Abort mid-address, then a clean read.
        set_cs(1'b1);
        pulse(1'b1, 1'b0, 1'b0, "R10");
        pulse(1'b1, 1'b0, 1'b0, "R10");
        pulse(1'b0, 1'b0, 1'b0, "R10");
        pulse(1'b1, 1'b0, 1'b0, "R10");
        pulse(1'b1, 1'b0, 1'b0, "R10");
        set_cs(1'b0);
        set_cs(1'b1);
        send_cmd(0, 2'b10, 8'h10, 1'b1);
        read_word(word_of(7'h10), 16, "R10");
        set_cs(1'b0);
        check(1'b0, 1'b0, "R1");

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule